// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Monitor

This block sits between the reference divider and the feedback divider of one synthesizer loop. It watches the rising edges of the divided reference pulse and the divided oscillator pulse, both sampled on a fast system clock. It turns the edge-to-edge timing error into up and down enables for a charge-pump driver. When neither enable is raised, the driver floats. Each correction pulse lasts at least a programmable number of system clock cycles. Because of this floor, coincident edges still produce a short balanced pulse on both enables, so the detector has no dead zone. A polarity bit swaps the roles of up and down so that the block can drive oscillators with either tuning slope.

A lock monitor counts reference edges that pass without an over-long error pulse. It raises a lock flag after enough of them in a row. The flag drops as soon as an error pulse exceeds the allowed length, so the lock signal behaves like a pulse-width-modulated indicator that sits high while the loop is settled.

A single multi-function pin is shared between loops. A three-bit selection chooses what drives it: the lock flag, the registered divided oscillator signal or the registered divided reference signal. The pin is enabled only in the loop that the selection names. Either standby bit floats the charge-pump driver and the pin, and clears the detector and lock state.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is held, up_en_o, dn_en_o and port_val_o are 0. cp_oe_o is 1 when neither standby bit is set.
- R2: With pol_pos_i=1, a reference rising edge sampled at clock edge k raises up_en_o from edge k. A feedback rising edge sampled d cycles later (d>0) ends the error. up_en_o then stays high for max(d, W) cycles and dn_en_o for W cycles from the feedback edge, where W is the minimum width. A feedback edge that leads the reference gives the mirror result.
- R3: Reference and feedback edges sampled on the same clock edge raise both up_en_o and dn_en_o for exactly W cycles. The internal up and down error states are never both set.
- R4: With pol_pos_i=0, the up and down enables are swapped relative to R2 and R3.
- R5: wd_sel_i[1] is the first width bit and wd_sel_i[0] the second. The codes 00, 10, 01 and 11 select W = MW_A, MW_B, MW_C and MW_D cycles (defaults 1, 3, 5, 7).
- R6: The lock flag rises on the LOCK_CYCLES-th consecutive reference edge (default 4) that is not accompanied by an over-long error. It only rises on a reference edge.
- R7: An error is over-long when up or down error state persists for more than ERR_MAX cycles (default 2). The lock flag falls on the next clock edge and the run of good edges restarts. With a leading reference of d >= ERR_MAX+1 cycles sampled at edge k, the flag is 1 after edge k+ERR_MAX+1 and 0 after edge k+ERR_MAX+2. A lead of d = ERR_MAX leaves the flag high.
- R8: The pin value is selected by {mode1_i, mode2_i}. 11 selects the lock flag. 00 selects the divided oscillator input delayed by one clock. 10 and 01 both select the divided reference input delayed by one clock.
- R9: port_oe_o is 1 only when loop_sel_i equals the LOOP_ID parameter and no standby bit is set.
- R10: When stby1_i or stby2_i is 1, cp_oe_o, port_oe_o, up_en_o and dn_en_o are 0 and port_val_o is 0. The detector and lock state are cleared at the next clock edge, so the lock flag is 0 after leaving standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_div_i | input | 1 | Divided reference pulse |
| vco_div_i | input | 1 | Divided oscillator pulse |
| pol_pos_i | input | 1 | 1 = positive polarity, 0 = up/down swapped |
| wd_sel_i | input | 2 | Minimum pulse-width code, [1] first bit, [0] second bit |
| stby1_i | input | 1 | Standby, full power-down |
| stby2_i | input | 1 | Standby, counters and outputs off |
| mode1_i | input | 1 | Pin selection bit 1 |
| mode2_i | input | 1 | Pin selection bit 2 |
| loop_sel_i | input | 1 | Loop that owns the shared pin |
| up_en_o | output | 1 | Charge-pump source enable |
| dn_en_o | output | 1 | Charge-pump sink enable |
| cp_oe_o | output | 1 | Charge-pump driver enable, 0 = high impedance |
| port_val_o | output | 1 | Shared pin value |
| port_oe_o | output | 1 | Shared pin drive enable |

## Verification
Suppose a stretch counter is loaded wrongly or decrements wrongly. The enable pulse length is then off by whole cycles, and the error shows at the outputs within W cycles of the first edge. A stuck error state shows as an enable that never drops. A good-edge counter that is cleared or advanced wrongly moves the lock rise on the shared pin by at least one reference period. A missed over-long detection leaves the pin high one cycle past the point where it should fall. Selection or standby faults show at the pin or its enable on the cycle after the control changes.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

  // Shared-pin source, indexed by {mode1, mode2}
  typedef enum logic [1:0] {
    PIN_VCO  = 2'b00,
    PIN_RSV  = 2'b01,
    PIN_REF  = 2'b10,
    PIN_LOCK = 2'b11
  } pin_sel_e;

  // Minimum correction width in clock cycles; code[1] is the first width bit
  function automatic int unsigned min_width(input logic [1:0] code,
                                            input int unsigned w_a,
                                            input int unsigned w_b,
                                            input int unsigned w_c,
                                            input int unsigned w_d);
    case (code)
      2'b00:   return w_a;
      2'b10:   return w_b;
      2'b01:   return w_c;
      default: return w_d;
    endcase
  endfunction

endpackage

// File: rtl/pfd_phase_det.sv
module pfd_phase_det
  import pfd_lock_pkg::*;
#(
  parameter int unsigned MW_A = 1,
  parameter int unsigned MW_B = 3,
  parameter int unsigned MW_C = 5,
  parameter int unsigned MW_D = 7   // must be the largest width
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ref_i,
  input  logic       vco_i,
  input  logic [1:0] wd_sel,
  output logic       ref_q,
  output logic       vco_q,
  output logic       ref_rise,
  output logic       vco_rise,
  output logic       raw_up,
  output logic       raw_dn,
  output logic       act_up,
  output logic       act_dn
);
  localparam int CW = $clog2(MW_D + 1);

  logic [CW-1:0] minw;
  logic [1:0]    trig;
  logic [1:0]    raw;
  logic [1:0]    act;
  logic          set_up, set_dn, both;

  assign minw = CW'(min_width(wd_sel, MW_A, MW_B, MW_C, MW_D));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      vco_q <= 1'b0;
    end else begin
      ref_q <= ref_i;
      vco_q <= vco_i;
    end
  end

  assign ref_rise = ref_i & ~ref_q;
  assign vco_rise = vco_i & ~vco_q;

  // Error state: set by its own edge, both cleared when the other edge arrives
  assign set_up = ref_rise | raw_up;
  assign set_dn = vco_rise | raw_dn;
  assign both   = set_up & set_dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_up <= 1'b0;
      raw_dn <= 1'b0;
    end else if (clr) begin
      raw_up <= 1'b0;
      raw_dn <= 1'b0;
    end else begin
      raw_up <= set_up & ~both;
      raw_dn <= set_dn & ~both;
    end
  end

  assign trig = {vco_rise, ref_rise};
  assign raw  = {raw_dn, raw_up};

  // One stretch counter per direction guarantees the minimum pulse
  for (genvar g = 0; g < 2; g++) begin : g_stretch
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (trig[g])        cnt <= minw;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
    end
    assign act[g] = raw[g] | (cnt != '0);
  end

  assign act_up = act[0];
  assign act_dn = act[1];

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int unsigned ERR_MAX     = 2,
  parameter int unsigned LOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ref_rise,
  input  logic err_act,
  output logic too_long,
  output logic locked
);
  localparam int EW = $clog2(ERR_MAX + 2);
  localparam int GW = $clog2(LOCK_CYCLES + 1);
  localparam logic [EW-1:0] ERR_LIM = EW'(ERR_MAX);
  localparam logic [EW-1:0] ERR_SAT = EW'(ERR_MAX + 1);
  localparam logic [GW-1:0] GOOD_N  = GW'(LOCK_CYCLES);

  logic [EW-1:0] err_run;
  logic [GW-1:0] good_cnt;

  assign too_long = err_run > ERR_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              err_run <= '0;
    else if (clr || !err_act) err_run <= '0;
    else if (err_run != ERR_SAT) err_run <= err_run + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (clr || too_long) begin
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (ref_rise) begin
      if (good_cnt != GOOD_N) good_cnt <= good_cnt + 1'b1;
      if (good_cnt >= GOOD_N - 1'b1) locked <= 1'b1;
    end
  end

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_lock_pkg::*;
#(
  parameter logic        LOOP_ID     = 1'b0,
  parameter int unsigned MW_A        = 1,
  parameter int unsigned MW_B        = 3,
  parameter int unsigned MW_C        = 5,
  parameter int unsigned MW_D        = 7,
  parameter int unsigned ERR_MAX     = 2,
  parameter int unsigned LOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_div_i,
  input  logic       vco_div_i,
  input  logic       pol_pos_i,
  input  logic [1:0] wd_sel_i,
  input  logic       stby1_i,
  input  logic       stby2_i,
  input  logic       mode1_i,
  input  logic       mode2_i,
  input  logic       loop_sel_i,
  output logic       up_en_o,
  output logic       dn_en_o,
  output logic       cp_oe_o,
  output logic       port_val_o,
  output logic       port_oe_o
);
  logic     stby;
  logic     ref_q, vco_q, ref_rise, vco_rise;
  logic     raw_up, raw_dn, act_up, act_dn;
  logic     too_long, locked;
  logic     pin_mux;
  pin_sel_e pin_sel;

  assign stby = stby1_i | stby2_i;

  pfd_phase_det #(.MW_A(MW_A), .MW_B(MW_B), .MW_C(MW_C), .MW_D(MW_D)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stby),
    .ref_i    (ref_div_i),
    .vco_i    (vco_div_i),
    .wd_sel   (wd_sel_i),
    .ref_q    (ref_q),
    .vco_q    (vco_q),
    .ref_rise (ref_rise),
    .vco_rise (vco_rise),
    .raw_up   (raw_up),
    .raw_dn   (raw_dn),
    .act_up   (act_up),
    .act_dn   (act_dn)
  );

  pfd_lock_mon #(.ERR_MAX(ERR_MAX), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stby),
    .ref_rise (ref_rise),
    .err_act  (raw_up | raw_dn),
    .too_long (too_long),
    .locked   (locked)
  );

  // Polarity swap and standby gating of the charge-pump enables
  assign up_en_o = ~stby & (pol_pos_i ? act_up : act_dn);
  assign dn_en_o = ~stby & (pol_pos_i ? act_dn : act_up);
  assign cp_oe_o = ~stby;

  // Shared pin routing
  assign pin_sel = pin_sel_e'({mode1_i, mode2_i});

  always_comb begin
    case (pin_sel)
      PIN_LOCK: pin_mux = locked;
      PIN_VCO:  pin_mux = vco_q;
      default:  pin_mux = ref_q;
    endcase
  end

  assign port_val_o = ~stby & pin_mux;
  assign port_oe_o  = ~stby & (loop_sel_i == LOOP_ID);

endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic stby,
  input logic pol,
  input logic ref_rise,
  input logic vco_rise,
  input logic raw_up,
  input logic raw_dn,
  input logic too_long,
  input logic locked,
  input logic up_en,
  input logic dn_en,
  input logic cp_oe,
  input logic port_oe
);

  // R2
  ref_lead_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && pol && !stby) |=> (up_en || stby || !pol));

  // R2
  vco_edge_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_rise && pol && !stby) |=> (dn_en || stby || !pol));

  // R3
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(raw_up && raw_dn));

  // R4
  neg_pol_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !pol && !stby) |=> (dn_en || stby || pol));

  // R6
  lock_on_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_rise));

  // R7
  long_err_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    too_long |=> !locked);

  // R10
  standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby |-> (!up_en && !dn_en && !cp_oe && !port_oe));

  // R10
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> (!locked && !raw_up && !raw_dn));

endmodule

bind pfd_lock_top pfd_lock_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stby     (stby),
  .pol      (pol_pos_i),
  .ref_rise (ref_rise),
  .vco_rise (vco_rise),
  .raw_up   (raw_up),
  .raw_dn   (raw_dn),
  .too_long (too_long),
  .locked   (locked),
  .up_en    (up_en_o),
  .dn_en    (dn_en_o),
  .cp_oe    (cp_oe_o),
  .port_oe  (port_oe_o)
);

// File: tb/tb_pfd_lock_top.sv
module tb_pfd_lock_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_div = 1'b0, vco_div = 1'b0;
  logic       pol = 1'b1;
  logic [1:0] wd = 2'b00;
  logic       sb1 = 1'b0, sb2 = 1'b0;
  logic       m1 = 1'b1, m2 = 1'b1;
  logic       lsel = 1'b0;
  logic       up_en, dn_en, cp_oe, port_val, port_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pfd_lock_top dut (
    .clk(clk), .rst_n(rst_n), .ref_div_i(ref_div), .vco_div_i(vco_div),
    .pol_pos_i(pol), .wd_sel_i(wd), .stby1_i(sb1), .stby2_i(sb2),
    .mode1_i(m1), .mode2_i(m2), .loop_sel_i(lsel),
    .up_en_o(up_en), .dn_en_o(dn_en), .cp_oe_o(cp_oe),
    .port_val_o(port_val), .port_oe_o(port_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample just after the next rising edge
  task automatic step(input logic r, input logic v);
    @(negedge clk);
    ref_div = r;
    vco_div = v;
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic       p;
    logic [1:0] code;
    int         d;
    int         exp_up;
    int         exp_dn;
  } vec_t;

  // Widths by code: 00->1, 10->3, 01->5, 11->7
  localparam vec_t VEC [10] = '{
    '{1'b1, 2'b00,  0, 1, 1},   // R3 R5
    '{1'b1, 2'b10,  0, 3, 3},   // R3 R5
    '{1'b1, 2'b01,  0, 5, 5},   // R3 R5
    '{1'b1, 2'b11,  0, 7, 7},   // R3 R5
    '{1'b1, 2'b00,  4, 4, 1},   // R2
    '{1'b1, 2'b10,  6, 6, 3},   // R2
    '{1'b1, 2'b11,  2, 7, 7},   // R2 floor dominates
    '{1'b1, 2'b10, -5, 3, 5},   // R2 feedback leads
    '{1'b0, 2'b00,  4, 1, 4},   // R4
    '{1'b0, 2'b10, -6, 6, 3}    // R4
  };

  int lock_hist [16];

  task automatic frame(input int d);
    for (int t = 0; t < 16; t++) begin
      step(t == 2, t == 2 + d);
      lock_hist[t] = port_val;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check(up_en == 1'b0 && dn_en == 1'b0, "R1 enables", {up_en, dn_en}, 0);
    check(port_val == 1'b0, "R1 pin", port_val, 0);
    check(cp_oe == 1'b1, "R1 cp_oe", cp_oe, 1);
    @(negedge clk);
    rst_n = 1'b1;
    m1 = 1'b0; m2 = 1'b0;

    // Vector table: pulse widths, polarity, width codes
    foreach (VEC[i]) begin
      int nu;
      int nd;
      nu = 0; nd = 0;
      pol = VEC[i].p;
      wd  = VEC[i].code;
      for (int t = 0; t < 30; t++) begin
        step(t == 8, t == 8 + VEC[i].d);
        if (up_en) nu++;
        if (dn_en) nd++;
      end
      check(nu == VEC[i].exp_up, $sformatf("R2/R3/R4/R5 vec%0d up", i), nu, VEC[i].exp_up);
      check(nd == VEC[i].exp_dn, $sformatf("R2/R3/R4/R5 vec%0d dn", i), nd, VEC[i].exp_dn);
    end
    pol = 1'b1;
    wd  = 2'b00;

    // R10 standby: outputs float, enables suppressed
    @(negedge clk);
    sb1 = 1'b1;
    step(1'b1, 1'b0);
    check(cp_oe == 1'b0 && port_oe == 1'b0, "R10 float", {cp_oe, port_oe}, 0);
    check(up_en == 1'b0, "R10 up suppressed", up_en, 0);
    step(1'b0, 1'b0);
    @(negedge clk);
    sb1 = 1'b0;

    // R6 lock acquisition on the pin (mode 11)
    m1 = 1'b1; m2 = 1'b1;
    for (int f = 0; f < 3; f++) frame(0);
    check(port_val == 1'b0, "R6 not yet locked", port_val, 0);
    frame(0);
    check(lock_hist[1] == 0 && lock_hist[2] == 1, "R6 rise on 4th edge",
          lock_hist[2], 1);
    check(port_oe == 1'b1, "R9 owner enabled", port_oe, 1);

    // R7 boundary: lead of ERR_MAX keeps lock
    frame(2);
    check(port_val == 1'b1, "R7 d=2 keeps lock", port_val, 1);
    // R7 lead of 3: high after edge k+3, low after k+4
    frame(3);
    check(lock_hist[5] == 1, "R7 still high at k+3", lock_hist[5], 1);
    check(lock_hist[6] == 0, "R7 low at k+4", lock_hist[6], 0);

    // relock, then R10 standby clears lock
    for (int f = 0; f < 4; f++) frame(0);
    check(port_val == 1'b1, "R6 relock", port_val, 1);
    @(negedge clk);
    sb2 = 1'b1;
    step(1'b0, 1'b0);
    check(port_val == 1'b0 && port_oe == 1'b0, "R10 pin in standby", port_val, 0);
    @(negedge clk);
    sb2 = 1'b0;
    step(1'b0, 1'b0);
    check(port_val == 1'b0, "R10 lock cleared", port_val, 0);

    // R8 pin routing
    m1 = 1'b0; m2 = 1'b0;
    step(1'b0, 1'b1);
    check(port_val == 1'b1, "R8 mode00 vco high", port_val, 1);
    step(1'b1, 1'b0);
    check(port_val == 1'b0, "R8 mode00 vco low", port_val, 0);
    m1 = 1'b1; m2 = 1'b0;
    step(1'b1, 1'b0);
    check(port_val == 1'b1, "R8 mode10 ref high", port_val, 1);
    step(1'b0, 1'b1);
    check(port_val == 1'b0, "R8 mode10 ref low", port_val, 0);
    m1 = 1'b0; m2 = 1'b1;
    step(1'b1, 1'b0);
    check(port_val == 1'b1, "R8 mode01 ref high", port_val, 1);
    step(1'b0, 1'b1);
    check(port_val == 1'b0, "R8 mode01 ignores vco", port_val, 0);

    // R9 pin owner selection
    lsel = 1'b1;
    step(1'b0, 1'b0);
    check(port_oe == 1'b0, "R9 other loop", port_oe, 0);
    lsel = 1'b0;
    step(1'b0, 1'b0);
    check(port_oe == 1'b1, "R9 back to owner", port_oe, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule